// File: doc/BRIEF.md
# Fail-Safe Clock Monitor

This block watches a fast primary clock with a slow reference clock. The reference clock comes from an internal oscillator that never stops. When the primary clock goes quiet, the block raises a failure flag. It also switches the device-clock source select over to the internal oscillator. The select stays on the internal oscillator until a reset or wake pulse, even if the primary clock starts running again. The block drives only the select. The glitch-free clock multiplexer that acts on it lives outside.

Two primary modes are supported:

- **Direct external clock:** monitoring begins as soon as reset or wake ends.
- **Crystal:** a crystal needs time to start. The device runs from the internal oscillator, and monitoring stays off, until the start-up timer reports a stable primary. A crystal that never starts therefore leaves only the start-up status low and never raises the failure flag.

Monitoring uses a probe handshake. At each reference edge the block toggles a probe. A synchronizer chain in the primary domain echoes the probe back. If the echo has not returned by the next reference edge, that sample period counts as missed.

Top module: `clk_failsafe_mon`

## Requirements
- R1: While `rst_n` is low, `clk_sel` is 1 (internal), and `start_ok`, `fail_flag` and `fail_irq` are 0.
- R2: With `xtal_mode`=0 (direct external clock), `clk_sel` becomes 0 (primary) at the first `ref_clk` rising edge after reset or a wake pulse. It then stays 0, with no failure flagged, for as long as the primary clock toggles.
- R3: When a monitored primary clock stops between two reference edges, the first following reference edge reports nothing. `fail_flag` is 1 and `clk_sel` is 1 after the second following reference edge (default of one missed sample period).
- R4: `fail_irq` is 1 exactly when `fail_flag` is 1 and `irq_en` is 1.
- R5: A `flag_clr` high at a reference edge clears `fail_flag` at that edge. The clear does not return `clk_sel` to 0, and a primary clock that restarts does not return it to 0 either.
- R6: Only reset or a `wake` pulse re-selects the primary after a failover. `wake` leaves `fail_flag` unchanged.
- R7: With `xtal_mode`=1, `clk_sel` is 1 and `start_ok` is 0 after reset or wake. At the first reference edge where `ost_done` is sampled high, `start_ok` becomes 1 and `clk_sel` becomes 0 together. `wake` clears `start_ok` even while `ost_done` is high.
- R8: With `xtal_mode`=1 and `ost_done` low, a primary clock that never toggles raises no failure flag.
- R9: No failure is reported while `clk_sel` is 1.
- R10: When a failure is detected at the same reference edge where `flag_clr` is high, the failure wins and `fail_flag` ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pri_clk | input | 1 | Primary clock under watch |
| ref_clk | input | 1 | Slow reference clock from the internal oscillator; all control state runs on it |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wake | input | 1 | Reset/wake pulse, synchronous to `ref_clk` |
| xtal_mode | input | 1 | Primary mode: 0 direct external clock, 1 crystal with start-up |
| ost_done | input | 1 | Start-up timer finished, synchronous to `ref_clk` |
| irq_en | input | 1 | Failure interrupt enable |
| flag_clr | input | 1 | Failure flag clear strobe, synchronous to `ref_clk` |
| clk_sel | output | 1 | Device clock source: 0 primary, 1 internal |
| start_ok | output | 1 | Primary start-up complete |
| fail_flag | output | 1 | Latched failure flag |
| fail_irq | output | 1 | Failure interrupt request |

## Verification
Detecting a failure and clearing the flag can fall on the same reference edge. The bench holds `flag_clr` high across the whole window while it stops the primary clock. It then samples after the second reference edge and expects the flag set and the select on the internal oscillator. One edge later, after the strobe has been dropped, it expects the flag still set. A second coincidence is a wake pulse while `ost_done` stays high in crystal mode. Here the bench expects the wake to win at that edge, and the start-up bit to return only at the next edge.

// File: rtl/fscm_pkg.sv
package fscm_pkg;
   typedef enum logic {
      SRC_PRI = 1'b0,
      SRC_INT = 1'b1
   } clk_src_t;
endpackage

// File: rtl/fscm_echo.sv
// Primary-domain return path of the probe handshake: a chain of flops
// clocked by the watched clock. The last stage is the echo seen by the
// reference domain; it stops following the probe once the primary stops.
module fscm_echo #(
   parameter int SYNC_STAGES = 2
) (
   input  logic pri_clk,
   input  logic rst_n,
   input  logic probe,
   output logic echo
);
   logic [SYNC_STAGES-1:0] chain;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("fscm_echo: SYNC_STAGES must be at least 2");
      end
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge pri_clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= probe;
            end
         end else begin : g_next
            always_ff @(posedge pri_clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign echo = chain[SYNC_STAGES-1];
endmodule

// File: rtl/fscm_detect.sv
// Reference-domain probe generator and miss counter. A probe is pending
// while probe and echo differ; a pending probe seen at a reference edge is
// a missed sample period. MISS_LIMIT missed periods in a row raise fail_hit.
module fscm_detect #(
   parameter int MISS_LIMIT = 1
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic wake,
   input  logic mon_en,
   input  logic echo,
   output logic probe,
   output logic fail_hit
);
   localparam int MW = (MISS_LIMIT < 2) ? 1 : $clog2(MISS_LIMIT + 1);
   localparam logic [MW-1:0] LAST_MISS = MW'(MISS_LIMIT - 1);

   generate
      if (MISS_LIMIT < 1) begin : g_bad_limit
         $error("fscm_detect: MISS_LIMIT must be at least 1");
      end
   endgenerate

   logic          armed;
   logic [MW-1:0] misses;
   logic          pending;

   assign pending  = probe ^ echo;
   assign fail_hit = armed & mon_en & ~wake & pending & (misses == LAST_MISS);

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         probe  <= 1'b0;
         armed  <= 1'b0;
         misses <= '0;
      end else if (wake || !mon_en) begin
         armed  <= 1'b0;
         misses <= '0;
      end else if (!armed) begin
         armed  <= 1'b1;
         probe  <= ~probe;
         misses <= '0;
      end else if (pending) begin
         if (fail_hit) begin
            armed  <= 1'b0;
            misses <= '0;
         end else begin
            misses <= misses + 1'b1;
         end
      end else begin
         probe  <= ~probe;
         misses <= '0;
      end
   end

   // A detected failure leaves the monitor disarmed afterwards.
   assert_disarm_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
      fail_hit |=> !armed);
endmodule

// File: rtl/fscm_ctrl.sv
// Source selection, start-up status, failover latch and failure flag.
module fscm_ctrl
   import fscm_pkg::*;
(
   input  logic     ref_clk,
   input  logic     rst_n,
   input  logic     wake,
   input  logic     xtal_mode,
   input  logic     ost_done,
   input  logic     flag_clr,
   input  logic     fail_hit,
   output clk_src_t clk_sel,
   output logic     start_ok,
   output logic     fail_flag,
   output logic     mon_en
);
   logic     failed_over;
   logic     start_d;
   logic     fover_d;
   clk_src_t sel_d;

   always_comb begin
      start_d = wake ? 1'b0 : (start_ok | ost_done);
      fover_d = wake ? 1'b0 : (failed_over | fail_hit);
      if (fover_d || (xtal_mode && !start_d)) sel_d = SRC_INT;
      else                                    sel_d = SRC_PRI;
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         start_ok    <= 1'b0;
         failed_over <= 1'b0;
         clk_sel     <= SRC_INT;
         fail_flag   <= 1'b0;
      end else begin
         start_ok    <= start_d;
         failed_over <= fover_d;
         clk_sel     <= sel_d;
         if (fail_hit)      fail_flag <= 1'b1;
         else if (flag_clr) fail_flag <= 1'b0;
      end
   end

   assign mon_en = (clk_sel == SRC_PRI);

   assert_latch_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (failed_over && !wake) |=> clk_sel == SRC_INT);
   assert_set_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
      fail_hit |=> fail_flag);
   assert_clear_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (fail_flag && flag_clr && !fail_hit) |=> !fail_flag);
   assert_start_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(start_ok) |-> $past(ost_done));
   assert_quiet_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (clk_sel == SRC_INT) |-> !fail_hit);
endmodule

// File: rtl/clk_failsafe_mon.sv
module clk_failsafe_mon
   import fscm_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MISS_LIMIT  = 1
) (
   input  logic pri_clk,
   input  logic ref_clk,
   input  logic rst_n,
   input  logic wake,
   input  logic xtal_mode,
   input  logic ost_done,
   input  logic irq_en,
   input  logic flag_clr,
   output logic clk_sel,
   output logic start_ok,
   output logic fail_flag,
   output logic fail_irq
);
   logic     probe;
   logic     echo;
   logic     fail_hit;
   logic     mon_en;
   clk_src_t sel_q;

   fscm_echo #(.SYNC_STAGES(SYNC_STAGES)) u_echo (
      .pri_clk (pri_clk),
      .rst_n   (rst_n),
      .probe   (probe),
      .echo    (echo)
   );

   fscm_detect #(.MISS_LIMIT(MISS_LIMIT)) u_detect (
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .wake     (wake),
      .mon_en   (mon_en),
      .echo     (echo),
      .probe    (probe),
      .fail_hit (fail_hit)
   );

   fscm_ctrl u_ctrl (
      .ref_clk   (ref_clk),
      .rst_n     (rst_n),
      .wake      (wake),
      .xtal_mode (xtal_mode),
      .ost_done  (ost_done),
      .flag_clr  (flag_clr),
      .fail_hit  (fail_hit),
      .clk_sel   (sel_q),
      .start_ok  (start_ok),
      .fail_flag (fail_flag),
      .mon_en    (mon_en)
   );

   assign clk_sel  = sel_q;
   assign fail_irq = fail_flag & irq_en;

   assert_irq_gate_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !irq_en |-> !fail_irq);
endmodule

// File: tb/tb_clk_failsafe_mon.sv
`timescale 1ns/1ps
module tb_clk_failsafe_mon;
   logic pri_clk = 1'b0;
   logic ref_clk = 1'b0;
   logic pri_run = 1'b1;
   logic rst_n = 1'b0;
   logic wake = 1'b0;
   logic xtal_mode = 1'b0;
   logic ost_done = 1'b0;
   logic irq_en = 1'b0;
   logic flag_clr = 1'b0;
   logic clk_sel, start_ok, fail_flag, fail_irq;
   int   n_checks = 0;
   int   n_fails  = 0;
   bit   done = 1'b0;

   // 125 MHz primary clock, gated by pri_run; 5 MHz reference clock.
   initial forever begin
      #4;
      if (pri_run) pri_clk = ~pri_clk;
   end
   initial forever #100 ref_clk = ~ref_clk;

   clk_failsafe_mon dut (
      .pri_clk(pri_clk), .ref_clk(ref_clk), .rst_n(rst_n), .wake(wake),
      .xtal_mode(xtal_mode), .ost_done(ost_done), .irq_en(irq_en),
      .flag_clr(flag_clr), .clk_sel(clk_sel), .start_ok(start_ok),
      .fail_flag(fail_flag), .fail_irq(fail_irq)
   );

   task automatic check(input string req, input string what,
                        input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic ref_neg();
      @(negedge ref_clk);
      #1;
   endtask

   task automatic wait_ref(input int n);
      for (int i = 0; i < n; i++) ref_neg();
   endtask

   task automatic pulse_wake();
      wake = 1'b1;
      ref_neg();
      wake = 1'b0;
   endtask

   task automatic t_reset();
      wait_ref(2);
      check("R1", "clk_sel", clk_sel, 1'b1);
      check("R1", "start_ok", start_ok, 1'b0);
      check("R1", "fail_flag", fail_flag, 1'b0);
      check("R1", "fail_irq", fail_irq, 1'b0);
   endtask

   task automatic t_ext_run();
      rst_n = 1'b1;
      ref_neg();
      check("R2", "clk_sel after first edge", clk_sel, 1'b0);
      wait_ref(10);
      check("R2", "clk_sel while running", clk_sel, 1'b0);
      check("R2", "fail_flag while running", fail_flag, 1'b0);
   endtask

   task automatic t_fail_and_clear();
      irq_en = 1'b0;
      pri_run = 1'b0;
      ref_neg();
      check("R3", "clk_sel one edge after stop", clk_sel, 1'b0);
      check("R3", "fail_flag one edge after stop", fail_flag, 1'b0);
      ref_neg();
      check("R3", "clk_sel two edges after stop", clk_sel, 1'b1);
      check("R3", "fail_flag two edges after stop", fail_flag, 1'b1);
      check("R4", "fail_irq with enable low", fail_irq, 1'b0);
      irq_en = 1'b1;
      #1;
      check("R4", "fail_irq with enable high", fail_irq, 1'b1);
      pri_run = 1'b1;
      wait_ref(5);
      check("R5", "clk_sel after primary restarts", clk_sel, 1'b1);
      flag_clr = 1'b1;
      ref_neg();
      flag_clr = 1'b0;
      check("R5", "fail_flag after clear", fail_flag, 1'b0);
      check("R4", "fail_irq after clear", fail_irq, 1'b0);
      check("R5", "clk_sel after clear", clk_sel, 1'b1);
      wait_ref(4);
      check("R9", "no new failure while internal", fail_flag, 1'b0);
   endtask

   task automatic t_wake_reselect();
      pulse_wake();
      check("R6", "clk_sel after wake", clk_sel, 1'b0);
      wait_ref(6);
      check("R2", "fail_flag after wake with primary running", fail_flag, 1'b0);
      check("R2", "clk_sel after wake with primary running", clk_sel, 1'b0);
   endtask

   task automatic t_clear_race();
      flag_clr = 1'b1;
      pri_run = 1'b0;
      ref_neg();
      check("R3", "clk_sel one edge after stop (race)", clk_sel, 1'b0);
      ref_neg();
      check("R10", "fail_flag with clear held", fail_flag, 1'b1);
      check("R10", "clk_sel with clear held", clk_sel, 1'b1);
      flag_clr = 1'b0;
      ref_neg();
      check("R10", "fail_flag after clear dropped", fail_flag, 1'b1);
      pri_run = 1'b1;
      wait_ref(2);
      pulse_wake();
      check("R6", "clk_sel after wake (race)", clk_sel, 1'b0);
      check("R6", "fail_flag kept through wake", fail_flag, 1'b1);
      flag_clr = 1'b1;
      ref_neg();
      flag_clr = 1'b0;
      check("R5", "fail_flag cleared on primary", fail_flag, 1'b0);
      check("R2", "clk_sel stays primary", clk_sel, 1'b0);
   endtask

   task automatic t_xtal();
      xtal_mode = 1'b1;
      ost_done = 1'b0;
      pri_run = 1'b0;
      pulse_wake();
      check("R7", "clk_sel after crystal wake", clk_sel, 1'b1);
      check("R7", "start_ok after crystal wake", start_ok, 1'b0);
      wait_ref(8);
      check("R8", "no flag while crystal dead", fail_flag, 1'b0);
      check("R8", "start_ok while crystal dead", start_ok, 1'b0);
      check("R9", "clk_sel while crystal dead", clk_sel, 1'b1);
      pri_run = 1'b1;
      wait_ref(2);
      check("R7", "clk_sel before timer done", clk_sel, 1'b1);
      ost_done = 1'b1;
      ref_neg();
      check("R7", "start_ok after timer done", start_ok, 1'b1);
      check("R7", "clk_sel after timer done", clk_sel, 1'b0);
      wait_ref(5);
      check("R7", "fail_flag on running crystal", fail_flag, 1'b0);
      pri_run = 1'b0;
      ref_neg();
      check("R3", "clk_sel one edge after crystal stop", clk_sel, 1'b0);
      ref_neg();
      check("R3", "fail_flag after crystal stop", fail_flag, 1'b1);
      check("R3", "clk_sel after crystal stop", clk_sel, 1'b1);
      pri_run = 1'b1;
      wait_ref(2);
      pulse_wake();
      check("R7", "start_ok cleared by wake", start_ok, 1'b0);
      check("R7", "clk_sel internal after wake", clk_sel, 1'b1);
      ref_neg();
      check("R7", "start_ok back next edge", start_ok, 1'b1);
      check("R7", "clk_sel primary next edge", clk_sel, 1'b0);
   endtask

   initial begin
      #200_000;
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_ext_run();
      t_fail_and_clear();
      t_wake_reselect();
      t_clear_race();
      t_xtal();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule